// File: doc/BRIEF.md
# Coherence Invalidate Queue Controller

This block sits between the coherence interconnect and a private cache. Incoming invalidate requests are acknowledged in the same cycle they are written into a small ordered queue, so the sender never waits for the cache itself. The queued invalidations are then applied to the cache, oldest first, at most one per cycle, whenever the local CPU's loads and stores leave the cache port free. Applying an entry moves that line from the shared state to the invalid state.

Every outgoing coherence message is compared, by line address, against the entries still pending. While any of them matches, the message is held with a stall output. A drain request gives a read-barrier view. The drain-done output stays low until every entry that was pending when the request began has been applied. Entries that arrive after the request began do not delay it.

Top module: `inv_queue_ctrl`

## Requirements
- R1: After reset the queue is empty, `inv_ack`, `msg_stall` and `cinv_valid` are low, and `drain_done` is high.
- R2: When `inv_valid` is high and the queue holds fewer than DEPTH entries, `inv_ack` is high in that same cycle, and the request is stored at that clock edge.
- R3: When the queue holds DEPTH entries and no entry leaves in that cycle, `inv_ack` is low and the request is not stored. The sender must hold it.
- R4: When the queue is full and an entry is applied in the same cycle, a pending request is acknowledged and stored in that cycle.
- R5: Entries are applied in arrival order. `cinv_valid` is high in each cycle where the queue is non-empty and `cache_busy` is low. `cinv_line` then carries the oldest line, which is `inv_addr[ADDR_W-1:OFFSET_W]` of that request.
- R6: While `cache_busy` is high, `cinv_valid` is low and no entry leaves the queue.
- R7: `msg_stall` is high in any cycle where `msg_valid` is high and the line bits `msg_addr[ADDR_W-1:OFFSET_W]` equal the line of any pending entry. The offset bits are ignored.
- R8: `msg_stall` is low when `msg_valid` is low or no pending entry matches. It falls in the cycle after the last matching entry is applied.
- R9: While `drain_req` is high, `drain_done` is low as long as any entry that was pending in the first cycle of the request has not yet been applied.
- R10: Entries stored during or after the first cycle of a drain request do not hold `drain_done` low.
- R11: `drain_done` is high whenever `drain_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Incoming invalidate request |
| inv_addr | input | ADDR_W | Byte address of the line to invalidate |
| inv_ack | output | 1 | Request accepted and queued in this cycle |
| msg_valid | input | 1 | Outgoing coherence message wants to go out |
| msg_addr | input | ADDR_W | Byte address that the outgoing message concerns |
| msg_stall | output | 1 | Hold the outgoing message; its line is still queued |
| cinv_valid | output | 1 | Invalidate the line on `cinv_line` in the cache this cycle |
| cinv_line | output | ADDR_W-OFFSET_W | Line address of the oldest pending entry |
| cache_busy | input | 1 | Cache port is serving the local CPU |
| drain_req | input | 1 | Read-barrier drain request |
| drain_done | output | 1 | All entries that were pending at the request have been applied |

## Verification
If the pointer or valid state is corrupted, a line appears out of order or twice on `cinv_line`. It can also vanish, so a held message never clears or clears too early. Each of these shows at most DEPTH cycles after the fault. A wrong occupancy count shows at once. The block either refuses a request while it has room, or acknowledges one while full, and that shows on `inv_ack` in the same cycle. A faulty drain counter makes `drain_done` rise before the older entries leave or stay low after they have left. A cycle-by-cycle model of queue contents and sequence numbers catches both cases on the first wrong cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;

  // Circular pointer advance for a queue of the given depth
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of simultaneous push and pop
  function automatic int unsigned occ_next(int unsigned occ, logic push, logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/iq_store.sv
module iq_store #(
  parameter int LINE_W = 10,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [LINE_W-1:0]         push_line,
  input  logic                      pop,
  output logic [LINE_W-1:0]         head_line,
  output logic [DEPTH*LINE_W-1:0]   ent_lines,
  output logic [DEPTH-1:0]          ent_vld,
  output logic [CNT_W-1:0]          occ,
  output logic                      empty,
  output logic                      full
);
  logic [LINE_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  assign empty     = (occ == '0);
  assign full      = (occ == CNT_W'(DEPTH));
  assign head_line = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(iq_pkg::wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(iq_pkg::wrap_inc(int'(rd_ptr), DEPTH));
      occ <= CNT_W'(iq_pkg::occ_next(int'(occ), push, pop));
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[i]    <= '0;
        ent_vld[i] <= 1'b0;
      end else begin
        if (pop && rd_ptr == PTR_W'(i)) ent_vld[i] <= 1'b0;
        if (push && wr_ptr == PTR_W'(i)) begin
          slot[i]    <= push_line;
          ent_vld[i] <= 1'b1;
        end
      end
    end
    assign ent_lines[i*LINE_W +: LINE_W] = slot[i];
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push) |-> pop);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_occ_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(occ) == int'($past(occ)) + int'($past(push)) - int'($past(pop)));
  assert_vld_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ent_vld) == int'(occ));
endmodule

// File: rtl/iq_lookup.sv
module iq_lookup #(
  parameter int LINE_W = 10,
  parameter int DEPTH  = 4
) (
  input  logic [LINE_W-1:0]       probe_line,
  input  logic [DEPTH*LINE_W-1:0] ent_lines,
  input  logic [DEPTH-1:0]        ent_vld,
  output logic                    hit
);
  logic [DEPTH-1:0] match_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match_vec[i] = ent_vld[i] && (ent_lines[i*LINE_W +: LINE_W] == probe_line);
  end

  assign hit = |match_vec;
endmodule

// File: rtl/iq_drain.sv
module iq_drain #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] occ,
  input  logic             pop,
  output logic             done
);
  logic             armed;
  logic [CNT_W-1:0] older_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      older_left <= '0;
    end else if (!req) begin
      armed      <= 1'b0;
      older_left <= '0;
    end else if (!armed) begin
      armed      <= 1'b1;
      older_left <= occ - CNT_W'(pop);
    end else if (pop && older_left != '0) begin
      older_left <= older_left - 1'b1;
    end
  end

  assign done = !req || (armed ? (older_left == '0) : (occ == '0));

  assert_drain_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> older_left <= occ);
  assert_drain_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && armed && !pop) |=> (!req || older_left == $past(older_left)));
endmodule

// File: rtl/inv_queue_ctrl.sv
module inv_queue_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 6,
  parameter int DEPTH    = 4,
  localparam int LINE_W  = ADDR_W - OFFSET_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              inv_ack,
  input  logic              msg_valid,
  input  logic [ADDR_W-1:0] msg_addr,
  output logic              msg_stall,
  output logic              cinv_valid,
  output logic [LINE_W-1:0] cinv_line,
  input  logic              cache_busy,
  input  logic              drain_req,
  output logic              drain_done
);
  logic                    apply_fire, enq_fire, q_empty, q_full, line_hit;
  logic [CNT_W-1:0]        q_occ;
  logic [DEPTH*LINE_W-1:0] q_lines;
  logic [DEPTH-1:0]        q_vld;
  logic [LINE_W-1:0]       in_line, probe_line;

  assign in_line    = inv_addr[ADDR_W-1:OFFSET_W];
  assign probe_line = msg_addr[ADDR_W-1:OFFSET_W];

  assign apply_fire = !q_empty && !cache_busy;
  assign enq_fire   = inv_valid && (!q_full || apply_fire);
  assign inv_ack    = enq_fire;
  assign cinv_valid = apply_fire;
  assign msg_stall  = msg_valid && line_hit;

  iq_store #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(enq_fire), .push_line(in_line), .pop(apply_fire),
    .head_line(cinv_line), .ent_lines(q_lines), .ent_vld(q_vld),
    .occ(q_occ), .empty(q_empty), .full(q_full)
  );

  iq_lookup #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_lookup (
    .probe_line(probe_line), .ent_lines(q_lines), .ent_vld(q_vld), .hit(line_hit)
  );

  iq_drain #(.CNT_W(CNT_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .req(drain_req), .occ(q_occ),
    .pop(apply_fire), .done(drain_done)
  );

  assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inv_ack |-> inv_valid);
  assert_full_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && cache_busy) |-> !inv_ack);
  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cache_busy |-> !cinv_valid);
  assert_busy_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_busy && !inv_ack) |=> $stable(q_occ));
  assert_stall_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_stall |-> (msg_valid && !q_empty));
  assert_drain_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_req |-> drain_done);
endmodule

// File: tb/inv_queue_ctrl_test.sv
module inv_queue_ctrl_test;
  localparam int AW = 16, OW = 6, DP = 4, LW = AW - OW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inv_valid = 0, msg_valid = 0, cache_busy = 0, drain_req = 0;
  logic [AW-1:0] inv_addr = '0, msg_addr = '0;
  logic inv_ack, msg_stall, cinv_valid, drain_done;
  logic [LW-1:0] cinv_line;

  int n_chk = 0, n_err = 0;
  int mseq[$];
  logic [LW-1:0] mline[$];
  int next_seq = 0, barrier = 0;
  bit armed_b = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  inv_queue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .inv_ack(inv_ack), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_stall(msg_stall), .cinv_valid(cinv_valid), .cinv_line(cinv_line),
    .cache_busy(cache_busy), .drain_req(drain_req), .drain_done(drain_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int line, input int off);
    return AW'((line << OW) | (off % (1 << OW)));
  endfunction

  task automatic step(input bit iv, input logic [AW-1:0] ia, input bit busy,
                      input bit mv, input logic [AW-1:0] ma, input bit dr);
    bit deq_e, ack_e, full_e, stall_e, done_e, older;
    int bar;
    @(negedge clk);
    inv_valid = iv; inv_addr = ia; cache_busy = busy;
    msg_valid = mv; msg_addr = ma; drain_req = dr;
    #2;
    full_e  = (mline.size() == DP);
    deq_e   = (mline.size() > 0) && !busy;
    ack_e   = iv && (!full_e || deq_e);
    stall_e = 0;
    foreach (mline[k]) if (mv && mline[k] == ma[AW-1:OW]) stall_e = 1;
    bar = armed_b ? barrier : next_seq;
    older = 0;
    foreach (mseq[k]) if (mseq[k] < bar) older = 1;
    done_e = !dr || !older;
    chk(inv_ack == ack_e, full_e ? (ack_e ? "R4 ack full+apply" : "R3 refuse full")
                                 : "R2 ack", int'(inv_ack), int'(ack_e));
    chk(cinv_valid == deq_e, busy ? "R6 busy hold" : "R5 apply", int'(cinv_valid), int'(deq_e));
    if (deq_e) chk(cinv_line == mline[0], "R5 order", int'(cinv_line), int'(mline[0]));
    chk(msg_stall == stall_e, stall_e ? "R7 stall" : "R8 no stall", int'(msg_stall), int'(stall_e));
    chk(drain_done == done_e, !dr ? "R11 idle done" : (older ? "R9 drain" : "R10 newer ignored"),
        int'(drain_done), int'(done_e));
    @(posedge clk);
    if (dr && !armed_b) barrier = next_seq;
    armed_b = dr;
    if (deq_e) begin void'(mline.pop_front()); void'(mseq.pop_front()); end
    if (ack_e) begin mline.push_back(ia[AW-1:OW]); mseq.push_back(next_seq); next_seq++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(inv_ack == 0, "R1 ack", int'(inv_ack), 0);
    chk(msg_stall == 0, "R1 stall", int'(msg_stall), 0);
    chk(cinv_valid == 0, "R1 cinv", int'(cinv_valid), 0);
    chk(drain_done == 1, "R1 done", int'(drain_done), 1);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(drain_done == 1 && cinv_valid == 0, "R1 after release", int'(cinv_valid), 0);

    // fill while busy, overflow attempt, probes with offset variations
    for (int i = 1; i <= 4; i++) step(1, mk(i, i * 7), 1, 1, mk(i, 3), 0);
    step(1, mk(5, 0), 1, 1, mk(3, 60), 0);
    step(1, mk(5, 0), 1, 1, mk(9, 3), 0);
    step(0, '0, 1, 0, mk(2, 0), 0);
    // release: stall on line 1 drops after its apply
    for (int i = 0; i < 5; i++) step(0, '0, 0, 1, mk(1, 11), 0);

    // full with apply in same cycle
    for (int i = 0; i < 4; i++) step(1, mk(20 + i, 1), 1, 0, '0, 0);
    step(1, mk(30, 2), 0, 1, mk(30, 5), 0);
    for (int i = 0; i < 6; i++) step(0, '0, 0, 1, mk(23, 0), 0);

    // drain with older and newer entries
    for (int i = 0; i < 3; i++) step(1, mk(40 + i, 0), 1, 0, '0, 0);
    step(1, mk(50, 0), 1, 0, '0, 1);
    for (int i = 0; i < 6; i++) step(1, mk(51 + i, 0), 0, 0, '0, 1);
    step(0, '0, 0, 0, '0, 0);
    for (int i = 0; i < 8; i++) step(0, '0, 0, 0, '0, 0);

    // pseudo-random sweep over a small line set
    for (int i = 0; i < 4000; i++) begin
      bit iv, bz, mv, dr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      iv = lfsr[0] | lfsr[1];
      bz = lfsr[2] & lfsr[3];
      mv = lfsr[4];
      dr = (i / 37) % 2 == 1 ? (lfsr[5] | lfsr[6] | lfsr[7]) : 1'b0;
      step(iv, mk(int'(lfsr[10:8]) % 6, int'(lfsr[15:11])), bz,
           mv, mk(int'(lfsr[13:11]) % 6, int'(lfsr[7:2])), dr);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule